// File: doc/BRIEF.md
# Set-wise Error Completion Tracker

This block keeps the books for a second-stage reduction that sums rounding-error terms for many data sets at once. Error terms reach it in any interleaving across sets. Each term carries a set identifier and a flag. The flag is high when the primary reduction of that set has already finished. The block queues the terms and folds the terms of each set pairwise through a pipelined adder. It keeps a set-indexed record of the primary-done flag and of the primary final sum. It can declare a set finished only when both records are present and the set has exactly one value left.

When a set finishes, the block sends the stored primary sum and the fully reduced error of that set through a correction adder. It then releases the set's entries, so the identifier can be used again. A set that had only one input value produces no error terms. The producer marks such a set when it writes the primary sum, and the block issues that sum with a zero correction. The adders are behavioural two's-complement stand-ins with the same pipelined timing as the real units.

Top module: `err_completion_tracker`

## Requirements
- R1: After reset, `res_valid` stays low and no set holds any pending term, flag or sum, so no result appears without new stimulus.
- R2: A result carries, on `res_sum`, the stored primary sum of the set. On `res_error` it carries the wrap-around (modulo 2^DATA_W) sum of all error terms of that set, and on `res_value` the modulo 2^DATA_W sum of the two. The result appears one cycle after the internal completion decision.
- R3: Error terms of different sets are never combined, even when terms of up to four sets arrive interleaved.
- R4: Each set produces exactly one result, and the result comes in a later cycle than the acceptance of its last error term.
- R5: A primary sum written with `sum_single` high is issued with `res_error` equal to 0 and `res_value` equal to the sum, without any error term.
- R6: A set whose accepted terms all had `err_primary_done` low is never completed, even if its occupancy has fallen to a single parked value.
- R7: If the primary sum of a set arrives after its last error term, completion waits for the sum.
- R8: Issuing a result clears that set's flag, sum and parked value, so a reused set identifier is reduced from a clean state.
- R9: Up to FIFO_D error terms may be accepted on consecutive cycles without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | An error term is offered this cycle |
| err_set | input | SET_W | Set identifier of the error term |
| err_value | input | DATA_W | Error term value (two's complement) |
| err_primary_done | input | 1 | The primary reduction of this set had finished when the term was produced |
| sum_valid | input | 1 | A primary final sum is offered this cycle |
| sum_set | input | SET_W | Set identifier of the primary sum |
| sum_value | input | DATA_W | Primary final sum |
| sum_single | input | 1 | The set had one input value and has no error terms |
| res_valid | output | 1 | A corrected result is presented |
| res_set | output | SET_W | Set identifier of the result |
| res_value | output | DATA_W | Corrected sum: primary sum plus reduced error |
| res_sum | output | DATA_W | Stored primary sum used for the correction |
| res_error | output | DATA_W | Fully reduced error of the set |

## Verification
The assertions rely on three things from the producer. A set identifier receives no new term or sum from the moment that set becomes complete until its result has been issued. A set receives no error term after the term that carried its primary-done flag. `err_valid` is never raised while the input queue is full. The stimulus satisfies these by giving every concurrent set its own identifier and by reusing an identifier only after its result has been observed. It spaces interleaved terms three cycles apart and limits back-to-back bursts to half the queue depth.

// File: rtl/ect_pkg.sv
package ect_pkg;

  // Action taken by the reduction engine in one cycle.
  typedef enum logic [2:0] {
    RULE_IDLE,
    RULE_PAIR_PIPE,
    RULE_PARK_PIPE,
    RULE_PAIR_FIFO,
    RULE_PARK_FIFO
  } rule_e;

  // A value leaving the adder has priority over the queue head.
  // A value is paired when its set already has a parked partner, otherwise it is parked.
  function automatic rule_e pick_rule(input logic pipe_v, input logic pipe_mate,
                                      input logic fifo_v, input logic fifo_mate);
    if (pipe_v) return pipe_mate ? RULE_PAIR_PIPE : RULE_PARK_PIPE;
    if (fifo_v) return fifo_mate ? RULE_PAIR_FIFO : RULE_PARK_FIFO;
    return RULE_IDLE;
  endfunction

endpackage

// File: rtl/ect_fifo.sv
module ect_fifo #(
  parameter int WIDTH = 19,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/ect_add_pipe.sv
module ect_add_pipe #(
  parameter int DATA_W = 16,
  parameter int SET_W  = 3,
  parameter int LAT    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [SET_W-1:0]  in_set,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_v,
  output logic [SET_W-1:0]  out_set,
  output logic [DATA_W-1:0] out_val
);
  logic [LAT-1:0]    v_q;
  logic [SET_W-1:0]  s_q [LAT];
  logic [DATA_W-1:0] d_q [LAT];
  logic [DATA_W-1:0] sum_in;

  // Behavioural stand-in for the adder: result formed at entry, carried LAT stages.
  assign sum_in = in_a + in_b;

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) v_q[0] <= 1'b0;
        else        v_q[0] <= in_v;
        s_q[0] <= in_set;
        d_q[0] <= sum_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) v_q[g] <= 1'b0;
        else        v_q[g] <= v_q[g-1];
        s_q[g] <= s_q[g-1];
        d_q[g] <= d_q[g-1];
      end
    end
  end

  assign out_v   = v_q[LAT-1];
  assign out_set = s_q[LAT-1];
  assign out_val = d_q[LAT-1];
endmodule

// File: rtl/ect_set_table.sv
module ect_set_table #(
  parameter int SET_W  = 3,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_inc_v,
  input  logic [SET_W-1:0]  f_inc_set,
  input  logic              f_dec_v,
  input  logic [SET_W-1:0]  f_dec_set,
  input  logic              p_inc_v,
  input  logic [SET_W-1:0]  p_inc_set,
  input  logic              p_dec_v,
  input  logic [SET_W-1:0]  p_dec_set,
  input  logic              b_wr_v,
  input  logic [SET_W-1:0]  b_wr_set,
  input  logic [DATA_W-1:0] b_wr_val,
  input  logic              b_clr_v,
  input  logic [SET_W-1:0]  b_clr_set,
  input  logic              fin_clr_v,
  input  logic [SET_W-1:0]  fin_clr_set,
  output logic [(1<<SET_W)-1:0] b_full,
  output logic [DATA_W-1:0]     b_val [1<<SET_W],
  output logic [(1<<SET_W)-1:0] last_one
);
  localparam int NSETS = 1 << SET_W;

  // One queue counter, one adder counter and one parked slot per set.
  for (genvar g = 0; g < NSETS; g++) begin : g_set
    localparam logic [SET_W-1:0] ID = SET_W'(g);
    logic [CNT_W-1:0]  fcnt, pcnt, occ;
    logic              bq;
    logic [DATA_W-1:0] vq;
    logic f_up, f_dn, p_up, p_dn, wr_hit, clr_hit;

    assign f_up    = f_inc_v && (f_inc_set == ID);
    assign f_dn    = f_dec_v && (f_dec_set == ID);
    assign p_up    = p_inc_v && (p_inc_set == ID);
    assign p_dn    = p_dec_v && (p_dec_set == ID);
    assign wr_hit  = b_wr_v && (b_wr_set == ID);
    assign clr_hit = (b_clr_v && (b_clr_set == ID)) || (fin_clr_v && (fin_clr_set == ID));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fcnt <= '0;
        pcnt <= '0;
        bq   <= 1'b0;
        vq   <= '0;
      end else begin
        fcnt <= fcnt + CNT_W'(f_up) - CNT_W'(f_dn);
        pcnt <= pcnt + CNT_W'(p_up) - CNT_W'(p_dn);
        if (wr_hit) begin
          bq <= 1'b1;
          vq <= b_wr_val;
        end else if (clr_hit) begin
          bq <= 1'b0;
        end
      end
    end

    assign occ         = fcnt + pcnt + CNT_W'(bq);
    assign last_one[g] = bq && (occ == CNT_W'(1));
    assign b_full[g]   = bq;
    assign b_val[g]    = vq;
  end
endmodule

// File: rtl/ect_side_mem.sv
module ect_side_mem #(
  parameter int SET_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_wr_v,
  input  logic [SET_W-1:0]  flag_wr_set,
  input  logic              flag_wr_bit,
  input  logic              sum_wr_v,
  input  logic [SET_W-1:0]  sum_wr_set,
  input  logic [DATA_W-1:0] sum_wr_val,
  input  logic              sum_wr_single,
  input  logic              clr_v,
  input  logic [SET_W-1:0]  clr_set,
  input  logic [SET_W-1:0]  rd_set,
  output logic [DATA_W-1:0] rd_sum,
  output logic [(1<<SET_W)-1:0] done_q,
  output logic [(1<<SET_W)-1:0] have_sum_q,
  output logic [(1<<SET_W)-1:0] single_q
);
  localparam int NSETS = 1 << SET_W;

  logic [DATA_W-1:0] sum_mem [NSETS];

  // Sum store: one write port from the primary side, one read port to the correction adder.
  always_ff @(posedge clk) begin
    if (sum_wr_v) sum_mem[sum_wr_set] <= sum_wr_val;
  end
  assign rd_sum = sum_mem[rd_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q     <= '0;
      have_sum_q <= '0;
      single_q   <= '0;
    end else begin
      if (flag_wr_v && flag_wr_bit) done_q[flag_wr_set] <= 1'b1;
      if (sum_wr_v) begin
        have_sum_q[sum_wr_set] <= 1'b1;
        single_q[sum_wr_set]   <= sum_wr_single;
      end
      if (clr_v) begin
        done_q[clr_set]     <= 1'b0;
        have_sum_q[clr_set] <= 1'b0;
        single_q[clr_set]   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/err_completion_tracker.sv
module err_completion_tracker
  import ect_pkg::*;
#(
  parameter int SET_W   = 3,
  parameter int DATA_W  = 16,
  parameter int FIFO_D  = 16,
  parameter int ADD_LAT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [SET_W-1:0]  err_set,
  input  logic [DATA_W-1:0] err_value,
  input  logic              err_primary_done,
  input  logic              sum_valid,
  input  logic [SET_W-1:0]  sum_set,
  input  logic [DATA_W-1:0] sum_value,
  input  logic              sum_single,
  output logic              res_valid,
  output logic [SET_W-1:0]  res_set,
  output logic [DATA_W-1:0] res_value,
  output logic [DATA_W-1:0] res_sum,
  output logic [DATA_W-1:0] res_error
);
  localparam int NSETS = 1 << SET_W;
  localparam int ENT_W = SET_W + DATA_W;
  localparam int CNT_W = $clog2(FIFO_D + ADD_LAT + 2) + 1;

  function automatic logic [DATA_W-1:0] fix_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  // Input queue
  logic [ENT_W-1:0]  head;
  logic              fifo_empty, fifo_full, fifo_pop;
  logic [SET_W-1:0]  head_set;
  logic [DATA_W-1:0] head_val;

  ect_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_D)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(err_valid), .din({err_set, err_value}),
    .pop(fifo_pop), .dout(head),
    .empty(fifo_empty), .full(fifo_full)
  );
  assign head_set = head[ENT_W-1:DATA_W];
  assign head_val = head[DATA_W-1:0];

  // Reduction adder
  logic              pv, add_in_v;
  logic [SET_W-1:0]  pset, add_in_set;
  logic [DATA_W-1:0] pval, add_a, add_b;

  ect_add_pipe #(.DATA_W(DATA_W), .SET_W(SET_W), .LAT(ADD_LAT)) u_add (
    .clk(clk), .rst_n(rst_n),
    .in_v(add_in_v), .in_set(add_in_set), .in_a(add_a), .in_b(add_b),
    .out_v(pv), .out_set(pset), .out_val(pval)
  );

  // Per-set occupancy and parked values
  logic [NSETS-1:0]  b_full, last_one;
  logic [DATA_W-1:0] b_val [NSETS];
  logic              park_v;
  logic [SET_W-1:0]  park_set;
  logic [DATA_W-1:0] park_val;
  logic              fin_fire;
  logic [SET_W-1:0]  fin_set;

  // Named rule events
  rule_e rule;
  logic  ev_pair_pipe, ev_park_pipe, ev_pair_fifo, ev_park_fifo;

  assign rule         = pick_rule(pv, b_full[pset], !fifo_empty, b_full[head_set]);
  assign ev_pair_pipe = (rule == RULE_PAIR_PIPE);
  assign ev_park_pipe = (rule == RULE_PARK_PIPE);
  assign ev_pair_fifo = (rule == RULE_PAIR_FIFO);
  assign ev_park_fifo = (rule == RULE_PARK_FIFO);

  assign fifo_pop   = ev_pair_fifo || ev_park_fifo;
  assign add_in_v   = ev_pair_pipe || ev_pair_fifo;
  assign add_in_set = ev_pair_pipe ? pset : head_set;
  assign add_a      = ev_pair_pipe ? pval : head_val;
  assign add_b      = b_val[add_in_set];
  assign park_v     = ev_park_pipe || ev_park_fifo;
  assign park_set   = ev_park_pipe ? pset : head_set;
  assign park_val   = ev_park_pipe ? pval : head_val;

  ect_set_table #(.SET_W(SET_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .f_inc_v(err_valid), .f_inc_set(err_set),
    .f_dec_v(fifo_pop), .f_dec_set(head_set),
    .p_inc_v(add_in_v), .p_inc_set(add_in_set),
    .p_dec_v(pv), .p_dec_set(pset),
    .b_wr_v(park_v), .b_wr_set(park_set), .b_wr_val(park_val),
    .b_clr_v(add_in_v), .b_clr_set(add_in_set),
    .fin_clr_v(fin_fire), .fin_clr_set(fin_set),
    .b_full(b_full), .b_val(b_val), .last_one(last_one)
  );

  // Flag and primary-sum stores
  logic [NSETS-1:0]  done_q, have_sum_q, single_q;
  logic [DATA_W-1:0] stored_sum;

  ect_side_mem #(.SET_W(SET_W), .DATA_W(DATA_W)) u_side (
    .clk(clk), .rst_n(rst_n),
    .flag_wr_v(err_valid), .flag_wr_set(err_set), .flag_wr_bit(err_primary_done),
    .sum_wr_v(sum_valid), .sum_wr_set(sum_set), .sum_wr_val(sum_value),
    .sum_wr_single(sum_single),
    .clr_v(fin_fire), .clr_set(fin_set),
    .rd_set(fin_set), .rd_sum(stored_sum),
    .done_q(done_q), .have_sum_q(have_sum_q), .single_q(single_q)
  );

  // Completion decision: lowest ready set wins
  logic [NSETS-1:0]  set_ready;
  logic [DATA_W-1:0] fin_err;

  assign set_ready = have_sum_q & (single_q | (done_q & last_one));
  assign fin_fire  = |set_ready;

  always_comb begin
    fin_set = '0;
    for (int i = NSETS - 1; i >= 0; i--) begin
      if (set_ready[i]) fin_set = SET_W'(i);
    end
  end

  assign fin_err = single_q[fin_set] ? '0 : b_val[fin_set];

  // Correction adder and result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_set   <= '0;
      res_value <= '0;
      res_sum   <= '0;
      res_error <= '0;
    end else begin
      res_valid <= fin_fire;
      if (fin_fire) begin
        res_set   <= fin_set;
        res_sum   <= stored_sum;
        res_error <= fin_err;
        res_value <= fix_add(stored_sum, fin_err);
      end
    end
  end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int SET_W  = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_valid,
  input logic [SET_W-1:0]  err_set,
  input logic              err_primary_done,
  input logic              sum_valid,
  input logic [SET_W-1:0]  sum_set,
  input logic              sum_single,
  input logic              res_valid,
  input logic [SET_W-1:0]  res_set,
  input logic [DATA_W-1:0] res_error,
  input logic              fifo_full,
  input logic              fin_fire,
  input logic [SET_W-1:0]  fin_set
);
  localparam int NSETS = 1 << SET_W;

  // Shadow view of each set, built only from the ports.
  logic [NSETS-1:0] saw_last, saw_sum, saw_single, issued;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saw_last   <= '0;
      saw_sum    <= '0;
      saw_single <= '0;
      issued     <= '0;
    end else begin
      if (err_valid) begin
        issued[err_set] <= 1'b0;
        if (err_primary_done) saw_last[err_set] <= 1'b1;
      end
      if (sum_valid) begin
        issued[sum_set]     <= 1'b0;
        saw_sum[sum_set]    <= 1'b1;
        saw_single[sum_set] <= sum_single;
        if (sum_single) saw_last[sum_set] <= 1'b1;
      end
      if (res_valid) begin
        saw_last[res_set]   <= 1'b0;
        saw_sum[res_set]    <= 1'b0;
        saw_single[res_set] <= 1'b0;
        issued[res_set]     <= 1'b1;
      end
    end
  end

  assert_fire_to_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin_fire |=> (res_valid && res_set == $past(fin_set)));

  assert_issue_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !issued[res_set]);

  assert_single_zero_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && saw_single[res_set]) |-> (res_error == '0));

  assert_needs_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> saw_last[res_set]);

  assert_needs_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> saw_sum[res_set]);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !err_valid);
endmodule

bind err_completion_tracker ect_checker #(.SET_W(SET_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .err_valid(err_valid), .err_set(err_set), .err_primary_done(err_primary_done),
  .sum_valid(sum_valid), .sum_set(sum_set), .sum_single(sum_single),
  .res_valid(res_valid), .res_set(res_set), .res_error(res_error),
  .fifo_full(fifo_full), .fin_fire(fin_fire), .fin_set(fin_set)
);

// File: tb/err_completion_tracker_bench.sv
module err_completion_tracker_bench;
  localparam int SET_W  = 3;
  localparam int DATA_W = 16;
  localparam int NSETS  = 1 << SET_W;
  localparam int NVEC   = 18;

  // Entry: {kind[1:0], set[2:0], value[15:0], flag}; kind 0 = error term, 1 = sum, 2 = single sum
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 16'd10,    1'b0},
    {2'd0, 3'd1, 16'hFFFD,  1'b0},
    {2'd1, 3'd2, 16'd1000,  1'b0},
    {2'd0, 3'd0, 16'd5,     1'b0},
    {2'd0, 3'd2, 16'd7,     1'b0},
    {2'd0, 3'd1, 16'd4,     1'b0},
    {2'd0, 3'd3, 16'd100,   1'b0},
    {2'd0, 3'd0, 16'hFFFE,  1'b1},
    {2'd1, 3'd0, 16'd500,   1'b0},
    {2'd0, 3'd2, 16'd1,     1'b0},
    {2'd2, 3'd4, 16'd777,   1'b0},
    {2'd0, 3'd3, 16'hFFCE,  1'b0},
    {2'd0, 3'd1, 16'd20,    1'b1},
    {2'd0, 3'd2, 16'd2,     1'b1},
    {2'd1, 3'd1, 16'd40,    1'b0},
    {2'd0, 3'd3, 16'd1,     1'b0},
    {2'd0, 3'd3, 16'd1,     1'b1},
    {2'd1, 3'd3, 16'd8,     1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              err_valid = 1'b0;
  logic [SET_W-1:0]  err_set = '0;
  logic [DATA_W-1:0] err_value = '0;
  logic              err_primary_done = 1'b0;
  logic              sum_valid = 1'b0;
  logic [SET_W-1:0]  sum_set = '0;
  logic [DATA_W-1:0] sum_value = '0;
  logic              sum_single = 1'b0;
  logic              res_valid;
  logic [SET_W-1:0]  res_set;
  logic [DATA_W-1:0] res_value, res_sum, res_error;

  err_completion_tracker u_err_completion_tracker (
    .clk(clk), .rst_n(rst_n),
    .err_valid(err_valid), .err_set(err_set), .err_value(err_value),
    .err_primary_done(err_primary_done),
    .sum_valid(sum_valid), .sum_set(sum_set), .sum_value(sum_value), .sum_single(sum_single),
    .res_valid(res_valid), .res_set(res_set), .res_value(res_value),
    .res_sum(res_sum), .res_error(res_error)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  int mon_cnt [NSETS];
  int mon_cyc [NSETS];
  logic [DATA_W-1:0] mon_val [NSETS];
  logic [DATA_W-1:0] mon_sum [NSETS];
  logic [DATA_W-1:0] mon_err [NSETS];
  int total_res = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      mon_cnt[res_set]++;
      mon_cyc[res_set] = cyc;
      mon_val[res_set] = res_value;
      mon_sum[res_set] = res_sum;
      mon_err[res_set] = res_error;
      total_res++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    for (int i = 0; i < NSETS; i++) begin
      mon_cnt[i] = 0;
      mon_cyc[i] = 0;
      mon_val[i] = '0;
      mon_sum[i] = '0;
      mon_err[i] = '0;
    end
  endtask

  // Drive one error term for one cycle, then leave two idle cycles.
  task automatic send_err(input int s, input logic [DATA_W-1:0] v, input bit f);
    @(negedge clk);
    err_valid = 1'b1; err_set = SET_W'(s); err_value = v; err_primary_done = f;
    @(negedge clk);
    err_valid = 1'b0; err_primary_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_sum(input int s, input logic [DATA_W-1:0] v, input bit single);
    @(negedge clk);
    sum_valid = 1'b1; sum_set = SET_W'(s); sum_value = v; sum_single = single;
    @(negedge clk);
    sum_valid = 1'b0; sum_single = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [DATA_W-1:0] exp_err  [NSETS];
  logic [DATA_W-1:0] exp_base [NSETS];
  int                last_cyc [NSETS];

  initial begin
    clr_mon();
    for (int i = 0; i < NSETS; i++) begin
      exp_err[i] = '0; exp_base[i] = '0; last_cyc[i] = 0;
    end
    idle(4);
    rst_n = 1'b1;
    idle(6);
    // R1: nothing issued after reset
    chk(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    chk(total_res == 0, "R1 no spontaneous result", total_res, 0);

    // Interleaved table: R2, R3, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]        kind;
      int                s;
      logic [DATA_W-1:0] v;
      bit                f;
      kind = VEC[i][21:20];
      s    = int'(VEC[i][19:17]);
      v    = VEC[i][16:1];
      f    = VEC[i][0];
      if (kind == 2'd0) begin
        send_err(s, v, f);
        exp_err[s] = exp_err[s] + v;
        if (f) last_cyc[s] = cyc;
      end else begin
        send_sum(s, v, kind == 2'd2);
        exp_base[s] = v;
      end
    end
    idle(200);
    for (int s = 0; s < 5; s++) begin
      chk(mon_cnt[s] == 1, "R4 one result per set", mon_cnt[s], 1);
      chk(mon_err[s] == exp_err[s], "R3 per-set error", int'(mon_err[s]), int'(exp_err[s]));
      chk(mon_sum[s] == exp_base[s], "R2 stored sum", int'(mon_sum[s]), int'(exp_base[s]));
      chk(mon_val[s] == DATA_W'(exp_base[s] + exp_err[s]), "R2 corrected value",
          int'(mon_val[s]), int'(DATA_W'(exp_base[s] + exp_err[s])));
      if (s < 4)
        chk(mon_cyc[s] > last_cyc[s], "R4 result after last term", mon_cyc[s], last_cyc[s] + 1);
    end
    chk(mon_err[4] == '0, "R5 single set zero error", int'(mon_err[4]), 0);

    // R6: without the done flag the set stays pending
    clr_mon();
    send_sum(5, 16'd1, 1'b0);
    send_err(5, 16'd9, 1'b0);
    idle(60);
    chk(mon_cnt[5] == 0, "R6 pending without done flag", mon_cnt[5], 0);
    send_err(5, 16'd3, 1'b1);
    idle(60);
    chk(mon_cnt[5] == 1, "R6 completes after flagged term", mon_cnt[5], 1);
    chk(mon_val[5] == 16'd13, "R6 value", int'(mon_val[5]), 13);

    // R7: sum after last term
    clr_mon();
    send_err(6, 16'd4, 1'b0);
    send_err(6, 16'd4, 1'b1);
    idle(60);
    chk(mon_cnt[6] == 0, "R7 waits for sum", mon_cnt[6], 0);
    send_sum(6, 16'd2, 1'b0);
    idle(10);
    chk(mon_cnt[6] == 1, "R7 completes on sum", mon_cnt[6], 1);
    chk(mon_val[6] == 16'd10, "R7 value", int'(mon_val[6]), 10);
    chk(mon_err[6] == 16'd8, "R7 error", int'(mon_err[6]), 8);

    // R8: reuse of set 0 starts clean
    clr_mon();
    send_sum(0, 16'd7, 1'b0);
    send_err(0, 16'd1, 1'b1);
    idle(60);
    chk(mon_cnt[0] == 1, "R8 reused set once", mon_cnt[0], 1);
    chk(mon_val[0] == 16'd8, "R8 reused set value", int'(mon_val[0]), 8);

    // R2: wrap-around of the correction adder
    clr_mon();
    send_sum(5, 16'h7FFF, 1'b0);
    send_err(5, 16'h0001, 1'b1);
    idle(60);
    chk(mon_val[5] == 16'h8000, "R2 wrap-around", int'(mon_val[5]), 32768);

    // R9: back-to-back burst of 8 terms
    clr_mon();
    send_sum(3, 16'd0, 1'b0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      err_valid = 1'b1; err_set = 3'd3; err_value = DATA_W'(k); err_primary_done = (k == 8);
    end
    @(negedge clk);
    err_valid = 1'b0; err_primary_done = 1'b0;
    idle(150);
    chk(mon_cnt[3] == 1, "R9 burst completes once", mon_cnt[3], 1);
    chk(mon_err[3] == 16'd36, "R9 burst error sum", int'(mon_err[3]), 36);

    // R5: single-value set issued promptly
    clr_mon();
    send_sum(7, 16'h1234, 1'b1);
    idle(4);
    chk(mon_cnt[7] == 1, "R5 single issued", mon_cnt[7], 1);
    chk(mon_val[7] == 16'h1234, "R5 single value", int'(mon_val[7]), 16'h1234);
    chk(mon_err[7] == '0, "R5 single error zero", int'(mon_err[7]), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule